// File: doc/BRIEF.md
# Reverse-Current Recovery Controller

This block sequences recovery from a reverse-current event on a protected power path that may include an external blocking FET. When reverse protection is enabled and the reverse comparator reports a new event, the controller forces both pass FETs off. It holds them off for a fixed recovery interval and keeps them off for as long as the reverse condition persists. It then waits for a restart delay whose length depends on whether the output is still above its undervoltage level. At the end it sends a one-cycle restart request to the startup sequencer, which runs a complete dual-stage start.

All timing is counted in ticks of an external timebase strobe. The three intervals are parameters in ticks. The defaults assume a 10 µs tick: 240 ticks of recovery, 42 ticks of short delay and 150 ticks of long delay. A restart is requested after every reverse event. The controller has no current-limit mode input, so latch-off behaviour elsewhere in the switch cannot suppress it. A status bit for the fault output is high while the reverse trip is active.

Top module: `rev_recovery_ctrl`

## Requirements
- R1: While `rev_en_i` is low, reverse-detect activity has no effect: the FETs stay on and no restart is requested. A trip needs a low-to-high change of `rev_det_i` seen while `rev_en_i` is high. A detect level that is already high when the enable rises does not trip.
- R2: A qualifying rising edge of `rev_det_i` sets `fets_off_o` and `rev_flag_o` at the next clock edge. The recovery phase then lasts until the first clock edge after `REC_TICKS` tick cycles have been counted.
- R3: If `rev_det_i` is still high when recovery would end, the FETs stay off and the flag stays high until `rev_det_i` is sampled low.
- R4: When recovery ends with the reverse condition clear, a restart delay follows. It is `FAST_TICKS` ticks if `out_ok_i` is high at that clock edge and `SLOW_TICKS` ticks if it is low. The FETs stay off and the flag is low during the delay.
- R5: At the end of the delay, `restart_o` is high for exactly one cycle, in the same cycle that `fets_off_o` returns low. The controller then stays idle until the next qualifying edge.
- R6: If `rev_det_i` is high at any clock edge during the restart delay, the controller returns to recovery and the full recovery interval starts again.
- R7: `rev_flag_o` is high only during recovery or while the controller waits for the reverse condition to clear. It is never high while the FETs are on.
- R8: Intervals advance only on cycles with `tick_i` high. With no ticks, the FETs stay off indefinitely and no restart occurs.
- R9: After synchronous reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rev_en_i | input | 1 | Reverse protection enable |
| rev_det_i | input | 1 | Reverse-detect comparator output |
| out_ok_i | input | 1 | Output is above its undervoltage level |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| fets_off_o | output | 1 | Force internal and external FETs off |
| rev_flag_o | output | 1 | Reverse fault status toward the fault flag |
| restart_o | output | 1 | One-cycle request for a fresh startup sequence |

## Verification
The bench sweeps the length of the detect pulse across the end-of-recovery boundary, with short pulses, a pulse that ends exactly at the boundary and pulses that overhang it. A design that checked the condition only once, or ended recovery one tick early, would give the wrong flag or off-time count. Each sweep point runs with both output levels, which catches a swapped or unlatched delay choice. A second detect pulse placed inside the delay must lengthen the off-time by a whole recovery interval; a design that ignored it would restart too early. Detect activity while disabled, an enable that rises under a high detect level, and a stalled timebase must all leave the off-time and restart counts at their expected values.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_RECOVER = 2'd1,
    ST_HOLD    = 2'd2,
    ST_DELAY   = 2'd3
  } rcr_state_t;
endpackage

// File: rtl/rcr_rise_detect.sv
module rcr_rise_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/rcr_tick_counter.sv
module rcr_tick_counter #(
  parameter int CW   = 8,
  parameter int MAXV = 240
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] SAT = CW'(MAXV);

  always_ff @(posedge clk) begin
    if (rst || clr_i)               cnt_o <= '0;
    else if (inc_i && cnt_o != SAT) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rev_recovery_ctrl.sv
module rev_recovery_ctrl #(
  parameter int REC_TICKS  = 240,
  parameter int FAST_TICKS = 42,
  parameter int SLOW_TICKS = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic rev_en_i,
  input  logic rev_det_i,
  input  logic out_ok_i,
  input  logic tick_i,
  output logic fets_off_o,
  output logic rev_flag_o,
  output logic restart_o
);
  import rcr_pkg::*;

  localparam int MAXT_A = (REC_TICKS > FAST_TICKS) ? REC_TICKS : FAST_TICKS;
  localparam int MAXT   = (MAXT_A > SLOW_TICKS) ? MAXT_A : SLOW_TICKS;
  localparam int CW     = $clog2(MAXT + 1);
  localparam logic [CW-1:0] REC_LEN  = CW'(REC_TICKS);
  localparam logic [CW-1:0] FAST_LEN = CW'(FAST_TICKS);
  localparam logic [CW-1:0] SLOW_LEN = CW'(SLOW_TICKS);

  rcr_state_t    st, st_n;
  logic          det_rise;
  logic          cnt_clr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] dly_len, dly_len_n;
  logic          restart_n;

  rcr_rise_detect u_rise (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (rev_det_i),
    .rise_o (det_rise)
  );

  rcr_tick_counter #(.CW(CW), .MAXV(MAXT)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .clr_i (cnt_clr),
    .inc_i (tick_i),
    .cnt_o (cnt)
  );

  // Next-state decision; the output level is sampled when recovery ends
  always_comb begin
    st_n      = st;
    cnt_clr   = 1'b0;
    restart_n = 1'b0;
    dly_len_n = dly_len;
    unique case (st)
      ST_IDLE: begin
        if (rev_en_i && det_rise) begin
          st_n    = ST_RECOVER;
          cnt_clr = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (cnt == REC_LEN) begin
          if (rev_det_i) begin
            st_n = ST_HOLD;
          end else begin
            st_n      = ST_DELAY;
            cnt_clr   = 1'b1;
            dly_len_n = out_ok_i ? FAST_LEN : SLOW_LEN;
          end
        end
      end
      ST_HOLD: begin
        if (!rev_det_i) begin
          st_n      = ST_DELAY;
          cnt_clr   = 1'b1;
          dly_len_n = out_ok_i ? FAST_LEN : SLOW_LEN;
        end
      end
      ST_DELAY: begin
        if (rev_det_i) begin
          st_n    = ST_RECOVER;
          cnt_clr = 1'b1;
        end else if (cnt == dly_len) begin
          st_n      = ST_IDLE;
          restart_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      dly_len    <= FAST_LEN;
      fets_off_o <= 1'b0;
      rev_flag_o <= 1'b0;
      restart_o  <= 1'b0;
    end else begin
      st         <= st_n;
      dly_len    <= dly_len_n;
      fets_off_o <= (st_n != ST_IDLE);
      rev_flag_o <= (st_n == ST_RECOVER) || (st_n == ST_HOLD);
      restart_o  <= restart_n;
    end
  end
endmodule

// File: rtl/rcr_checker.sv
module rcr_checker (
  input logic clk,
  input logic rst,
  input logic rev_en_i,
  input logic rev_det_i,
  input logic fets_off_o,
  input logic rev_flag_o,
  input logic restart_o
);
  // R1: idle and disabled at this edge means still on at the next
  p_disabled_no_trip_r1: assert property (@(posedge clk) disable iff (rst)
    (!fets_off_o && !rev_en_i) |=> !fets_off_o);

  // R2: entering the off state always begins with the flag
  p_entry_flags_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fets_off_o) |-> rev_flag_o);

  // R3 and R6: a present reverse condition keeps the FETs off
  p_det_holds_off_r3: assert property (@(posedge clk) disable iff (rst)
    (fets_off_o && rev_det_i) |=> (fets_off_o && !restart_o));

  // R5: restart is a single-cycle pulse
  p_restart_single_r5: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o);

  // R5: restart coincides with the FETs coming back on
  p_restart_on_release_r5: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (!fets_off_o && $past(fets_off_o)));

  // R7: flag only while off
  p_flag_only_off_r7: assert property (@(posedge clk) disable iff (rst)
    rev_flag_o |-> fets_off_o);
endmodule

bind rev_recovery_ctrl rcr_checker i_rcr_checker (
  .clk        (clk),
  .rst        (rst),
  .rev_en_i   (rev_en_i),
  .rev_det_i  (rev_det_i),
  .fets_off_o (fets_off_o),
  .rev_flag_o (rev_flag_o),
  .restart_o  (restart_o)
);

// File: tb/test_rev_recovery_ctrl.sv
module test_rev_recovery_ctrl;
  localparam int REC  = 8;
  localparam int FST  = 3;
  localparam int SLW  = 5;
  localparam int WIN  = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rev_en = 1'b0, rev_det = 1'b0, out_ok = 1'b0, tick = 1'b0;
  logic fets_off, rev_flag, restart;

  int n_chk = 0;
  int n_err = 0;
  int m_off, m_flag, m_rst, m_rst_at;

  always #5 clk = ~clk;

  rev_recovery_ctrl #(.REC_TICKS(REC), .FAST_TICKS(FST), .SLOW_TICKS(SLW)) i_rev_recovery_ctrl (
    .clk(clk), .rst(rst), .rev_en_i(rev_en), .rev_det_i(rev_det),
    .out_ok_i(out_ok), .tick_i(tick),
    .fets_off_o(fets_off), .rev_flag_o(rev_flag), .restart_o(restart)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Detect high for cycles [0,h) and at cycle s2 (if s2>=0); enable high from en_at
  task automatic scenario(input int h, input int s2, input logic ok,
                          input int en_at, input logic tk);
    m_off = 0; m_flag = 0; m_rst = 0; m_rst_at = -1;
    out_ok = ok;
    tick   = tk;
    for (int c = 0; c < WIN; c++) begin
      @(negedge clk);
      if (fets_off) m_off++;
      if (rev_flag) m_flag++;
      if (restart) begin
        m_rst++;
        if (m_rst_at < 0) m_rst_at = c;
      end
      rev_en  = (c >= en_at);
      rev_det = (c < h) || (s2 >= 0 && c == s2);
    end
    rev_det = 1'b0;
  endtask

  task automatic drain();
    rev_det = 1'b0;
    tick    = 1'b1;
    repeat (WIN) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 fets_off", fets_off, 0);
    check("R9 flag", rev_flag, 0);
    check("R9 restart", restart, 0);

    // R2 R3 R4 R5: sweep of detect length and output level
    for (int okv = 0; okv < 2; okv++) begin
      for (int h = 1; h <= REC + 6; h++) begin
        int fl, dl;
        scenario(h, -1, logic'(okv), 0, 1'b1);
        dl = (okv != 0) ? FST : SLW;
        fl = (h > REC + 1) ? h : REC + 1;
        check(h > REC + 1 ? "R3 flag cycles" : "R2 flag cycles", m_flag, fl);
        check("R4 off cycles", m_off, fl + dl + 1);
        check("R5 restart count", m_rst, 1);
        check("R5 restart position", m_rst_at, fl + dl + 2);
        drain();
      end
    end

    // R6: second detect inside the delay restarts recovery
    for (int okv = 0; okv < 2; okv++) begin
      int dl;
      dl = (okv != 0) ? FST : SLW;
      for (int d = 1; d <= dl; d++) begin
        scenario(1, REC + 1 + d, logic'(okv), 0, 1'b1);
        check("R6 flag cycles", m_flag, 2 * (REC + 1));
        check("R6 off cycles", m_off, (REC + 1 + d) + (REC + 1) + dl + 1);
        check("R6 restart count", m_rst, 1);
        drain();
      end
    end

    // R1: detect activity while disabled is ignored
    scenario(1, 10, 1'b1, WIN + 1, 1'b1);
    check("R1 disabled off cycles", m_off, 0);
    check("R1 disabled restart", m_rst, 0);
    drain();
    // R1: enable rising under an already-high detect level
    scenario(20, -1, 1'b1, 5, 1'b1);
    check("R1 level no trip off", m_off, 0);
    check("R1 level no trip flag", m_flag, 0);
    drain();

    // R3: condition never clears within the window
    scenario(WIN, -1, 1'b1, 0, 1'b1);
    check("R3 held off cycles", m_off, WIN - 1);
    check("R3 held restart", m_rst, 0);
    drain();

    // R8: no ticks, no progress
    scenario(1, -1, 1'b1, 0, 1'b0);
    check("R8 stalled off cycles", m_off, WIN - 1);
    check("R8 stalled flag cycles", m_flag, WIN - 1);
    check("R8 stalled restart", m_rst, 0);
    drain();
    // R5: idle afterwards
    check("R5 idle after drain", fets_off, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule